// File: doc/BRIEF.md
# Pipeline Register File with Write-Back Bypass

This block holds the general-purpose registers of a five-stage in-order core: 32 registers of 32 bits each. The decode stage presents the fetched instruction word. The block pulls the two source register numbers out of fixed fields of that word and returns both operand values combinationally in the same cycle. The write-back stage drives one write port, made up of an enable, a register number and data, all taken together from the last pipeline register. The write lands on the next rising clock edge.

The block models the rule "write early in the cycle, read late". When write-back targets the same register that decode is reading in that cycle, the read returns the data being written rather than the stale stored value. Register 0 is hard-wired to zero. A synchronous active-high reset clears every register.

All ports are plain level signals. The block has no valid/ready pair. Writes are never refused and reads are never stalled, so no back-pressure exists at this edge; the pipeline that surrounds the block handles stalling.

Top module: `pipe_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register is cleared to zero, and afterwards both read ports return 0 for every register number.
- R2: When `wb_en` is 1 and `wb_idx` is not 0 at a rising edge, register `wb_idx` holds `wb_data` from that edge on.
- R3: When `wb_en` is 0 at a rising edge, no register changes, whatever `wb_idx` and `wb_data` carry.
- R4: Read port A is addressed by instruction bits 25:21 and read port B by bits 20:16. No other instruction bit affects either output.
- R5: When `wb_en` is 1, `wb_idx` is nonzero and `wb_idx` equals a port's register number, that port returns `wb_data` in the same cycle, before the edge that stores it.
- R6: Register 0 always reads as zero. A write to register 0 is discarded, and it is not forwarded through the same-cycle path either.
- R7: When `wb_en` is 0, a port whose register number matches `wb_idx` returns the stored value, not `wb_data`.
- R8: The two read ports are independent. Both may address the same register, or different ones, in the same cycle, and each returns its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the write and the reset take effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_instr | input | 32 | Instruction word in the decode stage; carries both source register fields |
| wb_en | input | 1 | Write enable from the write-back stage |
| wb_idx | input | 5 | Destination register number from the write-back stage |
| wb_data | input | 32 | Result data from the write-back stage |
| opa_data | output | 32 | Value of the register named by instruction bits 25:21 |
| opb_data | output | 32 | Value of the register named by instruction bits 20:16 |

## Verification
The assertions assume that `wb_en`, `wb_idx` and `wb_data` are driven to known values in every cycle after reset is released. They also assume that the instruction word is stable while the outputs are being compared. The stimulus meets both conditions:
- It changes all inputs only on the falling clock edge.
- It parks the write port with the enable low between writes.
- It samples the outputs a fixed interval after each change, well before the next rising edge.

Same-cycle bypass cases are set up by presenting a write and a matching read together within one low clock phase.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_ENTRIES  = 32;
  localparam int RF_DATA_W   = 32;
  localparam int RF_INSTR_W  = 32;
  localparam int RF_IDX_W    = $clog2(RF_ENTRIES);
  // Operand field positions in the decode-stage instruction word
  localparam int RF_SRCA_LSB = 21;
  localparam int RF_SRCB_LSB = 16;
  localparam int RF_PORTS    = 2;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int ENTRIES = rf_pkg::RF_ENTRIES,
  parameter int DATA_W  = rf_pkg::RF_DATA_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [ENTRIES-1:0][DATA_W-1:0]  cells
);
  // Entry 0 has no storage at all: it is tied to zero.
  assign cells[0] = '0;

  for (genvar k = 1; k < ENTRIES; k++) begin : g_cell
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (rst)      cells[k] <= '0;
      else if (hit) cells[k] <= wr_data;
    end

    assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_idx == IDX_W'(k))) |=> $stable(cells[k]));

    assert_store_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_idx == IDX_W'(k))) |=> (cells[k] == $past(wr_data)));
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int ENTRIES = rf_pkg::RF_ENTRIES,
  parameter int DATA_W  = rf_pkg::RF_DATA_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0][DATA_W-1:0]  cells,
  input  logic [IDX_W-1:0]                rd_idx,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data
);
  logic is_zero;
  logic fwd;

  assign is_zero = (rd_idx == '0);
  assign fwd     = wr_en && (wr_idx == rd_idx);

  always_comb begin
    if (is_zero)  rd_data = '0;
    else if (fwd) rd_data = wr_data;
    else          rd_data = cells[rd_idx];
  end

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0) |-> (rd_data == '0));

  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == rd_idx) && (rd_idx != '0)) |-> (rd_data == wr_data));

  assert_no_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && (rd_idx != '0)) |-> (rd_data == cells[rd_idx]));
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
  parameter int ENTRIES  = rf_pkg::RF_ENTRIES,
  parameter int DATA_W   = rf_pkg::RF_DATA_W,
  parameter int INSTR_W  = rf_pkg::RF_INSTR_W,
  parameter int SRCA_LSB = rf_pkg::RF_SRCA_LSB,
  parameter int SRCB_LSB = rf_pkg::RF_SRCB_LSB,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int NPORTS  = rf_pkg::RF_PORTS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] dec_instr,
  input  logic               wb_en,
  input  logic [IDX_W-1:0]   wb_idx,
  input  logic [DATA_W-1:0]  wb_data,
  output logic [DATA_W-1:0]  opa_data,
  output logic [DATA_W-1:0]  opb_data
);
  logic [ENTRIES-1:0][DATA_W-1:0] cells;
  logic [NPORTS-1:0][IDX_W-1:0]   src_idx;
  logic [NPORTS-1:0][DATA_W-1:0]  src_data;
  logic                           unused_instr;

  assign src_idx[0]   = dec_instr[SRCA_LSB +: IDX_W];
  assign src_idx[1]   = dec_instr[SRCB_LSB +: IDX_W];
  assign unused_instr = ^dec_instr;

  rf_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wb_en),
    .wr_idx  (wb_idx),
    .wr_data (wb_data),
    .cells   (cells)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rf_read_port #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .cells   (cells),
      .rd_idx  (src_idx[p]),
      .wr_en   (wb_en),
      .wr_idx  (wb_idx),
      .wr_data (wb_data),
      .rd_data (src_data[p])
    );
  end

  assign opa_data = src_data[0];
  assign opb_data = src_data[1];

  // R8: two ports naming the same register return the same value
  assert_ports_agree_R8: assert property (@(posedge clk) disable iff (rst)
    (src_idx[0] == src_idx[1]) |-> (opa_data == opb_data));
endmodule

// File: tb/sim_pipe_regfile.sv
`timescale 1ns/1ps
module sim_pipe_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] dec_instr;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic [31:0] opa_data;
  logic [31:0] opb_data;

  int          n_run  = 0;
  int          n_fail = 0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  pipe_regfile u0 (
    .clk(clk), .rst(rst), .dec_instr(dec_instr), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data), .opa_data(opa_data), .opb_data(opb_data)
  );

  function automatic logic [31:0] mk_instr(input logic [4:0] a, input logic [4:0] b,
                                           input logic [5:0] top, input logic [15:0] low);
    return {top, a, b, low};
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'h9E37_79B9 * (i + 1) ^ 32'h0F0F_1234;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    dec_instr = mk_instr(a, b, 6'h2B, 16'hC3A5);
    #1;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    wb_en = 1'b1; wb_idx = idx; wb_data = d;
    @(negedge clk);
    wb_en = 1'b0; wb_idx = '0; wb_data = '0;
    if (idx != 0) model[idx] = d;
  endtask

  task automatic t_reset;
    wr(5'd9, 32'h1234_5678);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    for (int i = 0; i < 32; i++) begin
      present(5'(i), 5'(31 - i));
      check("R1 port A", opa_data, 32'h0);
      check("R1 port B", opb_data, 32'h0);
    end
  endtask

  task automatic t_write_all;
    for (int i = 1; i < 32; i++) wr(5'(i), pat(i));
    for (int i = 0; i < 32; i++) begin
      present(5'(i), 5'(i));
      check("R2 port A", opa_data, model[i]);
      check("R8 same reg port B", opb_data, model[i]);
    end
  endtask

  task automatic t_fields;
    for (int i = 1; i < 32; i++) begin
      @(negedge clk);
      dec_instr = mk_instr(5'(i), 5'(32 - i), 6'(i * 7), 16'(i * 4099));
      #1;
      check("R4 bits 25:21", opa_data, model[i]);
      check("R4 bits 20:16 R8", opb_data, model[32 - i]);
    end
  endtask

  task automatic t_no_enable;
    @(negedge clk);
    wb_en = 1'b0; wb_idx = 5'd12; wb_data = 32'hDEAD_0000;
    @(negedge clk);
    wb_idx = '0; wb_data = '0;
    present(5'd12, 5'd3);
    check("R3 reg 12 unchanged", opa_data, model[12]);
    check("R3 reg 3 unchanged", opb_data, model[3]);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    wb_en = 1'b1; wb_idx = 5'd7; wb_data = 32'hCAFE_F00D;
    dec_instr = mk_instr(5'd7, 5'd8, 6'h00, 16'h0000);
    #1;
    check("R5 port A same cycle", opa_data, 32'hCAFE_F00D);
    check("R5 port B other reg", opb_data, model[8]);
    dec_instr = mk_instr(5'd8, 5'd7, 6'h3F, 16'hFFFF);
    #1;
    check("R5 port B same cycle", opb_data, 32'hCAFE_F00D);
    @(negedge clk);
    wb_en = 1'b0; wb_idx = '0; wb_data = '0;
    model[7] = 32'hCAFE_F00D;
    present(5'd7, 5'd7);
    check("R5 stored after edge", opa_data, 32'hCAFE_F00D);
  endtask

  task automatic t_bypass_off;
    @(negedge clk);
    wb_en = 1'b0; wb_idx = 5'd20; wb_data = 32'h5555_AAAA;
    dec_instr = mk_instr(5'd20, 5'd20, 6'h11, 16'h2222);
    #1;
    check("R7 port A stored", opa_data, model[20]);
    check("R7 port B stored", opb_data, model[20]);
    @(negedge clk);
    wb_idx = '0; wb_data = '0;
  endtask

  task automatic t_zero;
    @(negedge clk);
    wb_en = 1'b1; wb_idx = 5'd0; wb_data = 32'hFFFF_FFFF;
    dec_instr = mk_instr(5'd0, 5'd0, 6'h3F, 16'hFFFF);
    #1;
    check("R6 no bypass A", opa_data, 32'h0);
    check("R6 no bypass B", opb_data, 32'h0);
    @(negedge clk);
    wb_en = 1'b0; wb_idx = '0; wb_data = '0;
    present(5'd0, 5'd1);
    check("R6 write dropped", opa_data, 32'h0);
    check("R6 neighbour intact", opb_data, model[1]);
  endtask

  initial begin
    rst = 1'b1; dec_instr = '0; wb_en = 1'b0; wb_idx = '0; wb_data = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_all();
    t_fields();
    t_no_enable();
    t_bypass();
    t_bypass_off();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule